// File: doc/BRIEF.md
# SMBus Host Transaction Engine

This block runs single SMBus host transactions on a two-wire open-drain bus. Software reaches it through a small byte-wide register port. It loads the target address with its direction bit, a command byte and up to two data bytes, and then writes a start strobe together with one of four protocol codes. The engine then runs the whole transaction on its own. It generates START, repeated START and STOP conditions, shifts the bytes out and in, and checks every acknowledge. It writes the bytes it reads into the data registers.

Status is reported through a busy flag and four sticky outcome flags: completed, device error, collision and killed. Software clears an outcome flag by writing a one to its bit. An interrupt output follows the outcome flags when the interrupt enable is set. The abort control ends a running transaction at once and leaves its own outcome flag set.

Bus timing comes from a fixed divider. Each bit slot lasts four quarter periods of `QDIV` clock cycles. If a target holds SCL low, the engine waits before it samples.

Top module: `smb_host`

## Requirements
- R1: The register map is as follows. Offset 0 is status: bit0 busy, bit1 completed, bit2 device error, bit3 collision, bit4 killed. Offset 2 is control: bit6 start strobe, which reads as 0; bits 4:2 protocol; bit1 kill strobe, which reads as 0; bit0 interrupt enable. Offset 3 is the command byte. Offset 4 holds the target address in bits 7:1 and the direction in bit0, where 1 means read. Offsets 5 and 6 are data bytes 0 and 1. Other offsets read as zero.
- R2: The write protocols put these bytes on the bus. Code 0 sends only the address byte. Code 1 sends the address byte and then the command byte. Code 2 adds data byte 0 after the command byte. Code 3 adds data byte 0 and then data byte 1. Each transaction starts with one START, ends with one STOP and sets the completed bit.
- R3: The read protocols work as follows. Code 1 reads one byte directly after the address, so only one START is used. Codes 2 and 3 first send the address with bit0 = 0 and then the command byte. They then issue a repeated START and the address with bit0 = 1. Received bytes land in data byte 0 and then data byte 1. The data is valid when the completed bit is set.
- R4: The engine ACKs every received byte except the last one, which it NACKs, and then it sends STOP.
- R5: If the target does not ACK an address or written byte, the engine sets device error, sends STOP and clears busy. The completed bit stays clear.
- R6: If the engine releases SDA for a transmitted 1 and samples SDA low, it sets the collision bit, clears busy and stops driving both lines.
- R7: A kill strobe written while busy clears busy and sets the killed bit. The completed bit is not set.
- R8: Writing a one to status bits 1 to 4 clears those bits. Writing zeros leaves them unchanged, and the busy bit cannot be written.
- R9: The irq output is high exactly when the interrupt enable is set and at least one of status bits 1 to 4 is set.
- R10: A start strobe written while busy is ignored, and the protocol field keeps its value while busy.
- R11: A start strobe with protocol code 4 to 7 sets device error at once. Busy is not set and neither bus line is pulled.
- R12: While the engine is idle, both SCL and SDA are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Completion/error interrupt |

## Verification
The main function is driven by a table that covers all eight combinations of protocol code and direction. A behavioural target on the bench records the written bytes, counts START and STOP conditions, and logs the master's acknowledge bits. For each combination it supplies fixed read data. Comparing the logged bytes separates the write protocols from each other. The START count and the register contents separate a direct read from a read behind a repeated START, and the two logged acknowledge bits confirm the ACK-then-NACK order of a word read. Directed cases cover an unknown address, an SDA line held low, a kill in mid-transfer, a start while busy, a reserved protocol code, and the interrupt and clear-by-one behaviour.

// File: rtl/smb_host.sv
module smb_host #(
  parameter int QDIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       irq
);
  localparam int QW = $clog2(QDIV) + 1;
  localparam logic [QW-1:0] QLAST = QW'(QDIV - 1);

  localparam logic [3:0] O_START = 4'd0, O_TAD = 4'd1, O_TAW = 4'd2, O_TAR = 4'd3,
                         O_CMD = 4'd4, O_D0 = 4'd5, O_D1 = 4'd6, O_RXA = 4'd7,
                         O_RXN = 4'd8, O_RX1N = 4'd9, O_STOP = 4'd10;

  logic busy, done, derr, berr, fail, ien;
  logic [2:0] proto;
  logic [7:0] cmd, adr, d0, d1, rx;
  logic [3:0] step, bitn, op;
  logic [1:0] ph;
  logic [QW-1:0] q;
  logic nak, err_stop;
  logic scl_w, sda_w;

  function automatic logic [3:0] seq_op(input logic [1:0] p, input logic rd, input logic [3:0] s);
    logic [3:0] r;
    r = O_STOP;
    case ({p, rd})
      3'b000, 3'b001: case (s) 4'd0: r = O_START; 4'd1: r = O_TAD; default: r = O_STOP; endcase
      3'b010: case (s) 4'd0: r = O_START; 4'd1: r = O_TAD; 4'd2: r = O_CMD; default: r = O_STOP; endcase
      3'b011: case (s) 4'd0: r = O_START; 4'd1: r = O_TAD; 4'd2: r = O_RXN; default: r = O_STOP; endcase
      3'b100: case (s) 4'd0: r = O_START; 4'd1: r = O_TAD; 4'd2: r = O_CMD; 4'd3: r = O_D0;
                default: r = O_STOP; endcase
      3'b101: case (s) 4'd0: r = O_START; 4'd1: r = O_TAW; 4'd2: r = O_CMD; 4'd3: r = O_START;
                4'd4: r = O_TAR; 4'd5: r = O_RXN; default: r = O_STOP; endcase
      3'b110: case (s) 4'd0: r = O_START; 4'd1: r = O_TAD; 4'd2: r = O_CMD; 4'd3: r = O_D0;
                4'd4: r = O_D1; default: r = O_STOP; endcase
      default: case (s) 4'd0: r = O_START; 4'd1: r = O_TAW; 4'd2: r = O_CMD; 4'd3: r = O_START;
                4'd4: r = O_TAR; 4'd5: r = O_RXA; 4'd6: r = O_RX1N; default: r = O_STOP; endcase
    endcase
    return r;
  endfunction

  assign op = err_stop ? O_STOP : seq_op(proto[1:0], adr[0], step);

  wire is_tx = (op >= O_TAD) && (op <= O_D1);
  wire is_rx = (op >= O_RXA) && (op <= O_RX1N);
  wire bit_slot = is_tx || is_rx;

  logic [7:0] txb;
  always_comb begin
    case (op)
      O_TAW:   txb = {adr[7:1], 1'b0};
      O_TAR:   txb = {adr[7:1], 1'b1};
      O_CMD:   txb = cmd;
      O_D0:    txb = d0;
      O_D1:    txb = d1;
      default: txb = adr;
    endcase
  end
  wire txbit = txb[~bitn[2:0]];

  wire qend     = (q == QLAST);
  wire stall    = (ph == 2'd1) && !scl_in;
  wire tick     = busy && qend && !stall;
  wire slot_end = tick && (ph == 2'd3);
  wire op_end   = slot_end && (!bit_slot || bitn == 4'd8);

  wire wr_ctl    = reg_wr && (reg_sel == 3'd2);
  wire start_req = wr_ctl && reg_wdata[6];
  wire kill_req  = wr_ctl && reg_wdata[1];

  always_comb begin
    scl_w = 1'b0;
    sda_w = 1'b0;
    if (busy) begin
      case (op)
        O_START: begin scl_w = (ph == 2'd0) ? scl_pull : (ph == 2'd3); sda_w = ph[1]; end
        O_STOP:  begin scl_w = (ph == 2'd0); sda_w = !ph[1]; end
        default: begin
          scl_w = (ph == 2'd0) || (ph == 2'd3);
          sda_w = (bitn == 4'd8) ? (op == O_RXA) : (is_tx && !txbit);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; derr <= 1'b0; berr <= 1'b0; fail <= 1'b0;
      ien <= 1'b0; proto <= '0; cmd <= '0; adr <= '0; d0 <= '0; d1 <= '0; rx <= '0;
      step <= '0; bitn <= '0; ph <= '0; q <= '0; nak <= 1'b0; err_stop <= 1'b0;
      scl_pull <= 1'b0; sda_pull <= 1'b0;
    end else begin
      scl_pull <= scl_w;
      sda_pull <= sda_w;
      if (reg_wr) begin
        case (reg_sel)
          3'd0: begin
            if (reg_wdata[1]) done <= 1'b0;
            if (reg_wdata[2]) derr <= 1'b0;
            if (reg_wdata[3]) berr <= 1'b0;
            if (reg_wdata[4]) fail <= 1'b0;
          end
          3'd2: begin
            ien <= reg_wdata[0];
            if (!busy) proto <= reg_wdata[4:2];
          end
          3'd3: cmd <= reg_wdata;
          3'd4: adr <= reg_wdata;
          3'd5: d0 <= reg_wdata;
          3'd6: d1 <= reg_wdata;
          default: ;
        endcase
      end
      if (busy) begin
        if (qend) q <= stall ? q : '0;
        else      q <= q + 1'b1;
        if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd1) begin
            if (is_tx) begin
              if (bitn != 4'd8) begin
                if (txbit && !sda_in) begin busy <= 1'b0; berr <= 1'b1; end
              end else if (sda_in) begin
                derr <= 1'b1;
                nak  <= 1'b1;
              end
            end
            if (is_rx && bitn != 4'd8) begin
              rx <= {rx[6:0], sda_in};
              if (bitn == 4'd7) begin
                if (op == O_RX1N) d1 <= {rx[6:0], sda_in};
                else              d0 <= {rx[6:0], sda_in};
              end
            end
          end
          if (slot_end && bit_slot) bitn <= (bitn == 4'd8) ? 4'd0 : bitn + 4'd1;
          if (op_end) begin
            if (op == O_STOP) begin
              busy <= 1'b0;
              if (!err_stop) done <= 1'b1;
              err_stop <= 1'b0;
            end else if (nak) begin
              err_stop <= 1'b1;
              nak <= 1'b0;
            end else begin
              step <= step + 4'd1;
            end
          end
        end
      end
      if (start_req && !busy) begin
        if (reg_wdata[4]) derr <= 1'b1;
        else begin
          busy <= 1'b1; step <= '0; bitn <= '0; ph <= '0; q <= '0;
          nak <= 1'b0; err_stop <= 1'b0;
        end
      end
      if (kill_req && busy) begin
        busy <= 1'b0;
        fail <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {3'b000, fail, berr, derr, done, busy};
      3'd2:    reg_rdata = {3'b000, proto, 1'b0, ien};
      3'd3:    reg_rdata = cmd;
      3'd4:    reg_rdata = adr;
      3'd5:    reg_rdata = d0;
      3'd6:    reg_rdata = d1;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = ien && (done || derr || berr || fail);
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       done,
  input logic       derr,
  input logic       berr,
  input logic       fail,
  input logic [2:0] proto,
  input logic       scl_pull,
  input logic       sda_pull
);
  wire ctl_wr = reg_wr && (reg_sel == 3'd2);

  a_r7_kill_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1] && busy) |=> (!busy && fail));

  a_r10_proto_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && busy) |=> $stable(proto));

  a_r11_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[6] && reg_wdata[4] && !busy) |=> (!busy && derr));

  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!scl_pull && !sda_pull));

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  a_r6_collision_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr) |-> !busy);
endmodule

bind smb_host smb_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .busy(busy), .done(done), .derr(derr), .berr(berr), .fail(fail), .proto(proto),
  .scl_pull(scl_pull), .sda_pull(sda_pull)
);

// File: tb/tb_smb_host.sv
`timescale 1ns/100ps
module tb_smb_host;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_sel = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl, sda, scl_pull, sda_pull, irq;
  logic s_drv = 1'b0, jam = 1'b0;

  assign scl = !scl_pull;
  assign sda = !(sda_pull || s_drv || jam);

  always #2.5 clk = !clk;

  smb_host dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_in(scl), .sda_in(sda), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .irq(irq)
  );

  int nchk = 0, nerr = 0, cyc = 0;

  // behavioural bus target
  logic act = 0, first = 0, sending = 0, just = 0, rpend = 0;
  logic [7:0] sh = '0, tx = '0;
  logic [7:0] wlog [4];
  logic mack [2];
  logic mlast = 0;
  int bitc = 0, wcnt = 0, rcnt = 0, mcnt = 0, starts = 0, stops = 0;

  function automatic logic [7:0] rbyte(input int n);
    return (n == 0) ? 8'hA5 : 8'h3C;
  endfunction

  always @(negedge sda) if (scl === 1'b1) begin
    act = 1; first = 1; bitc = 0; sending = 0; rpend = 0; just = 1; s_drv = 0; starts++;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    act = 0; s_drv = 0; stops++;
  end
  always @(posedge scl) if (act) begin
    if (bitc < 8) begin
      if (!sending) sh = {sh[6:0], sda};
    end else if (sending) begin
      mlast = !sda;
      if (mcnt < 2) mack[mcnt] = !sda;
      mcnt++;
    end
  end
  always @(negedge scl) if (act) begin
    if (just) just = 0;
    else begin
      bitc = (bitc == 8) ? 0 : bitc + 1;
      if (bitc == 8) begin
        if (sending) s_drv = 0;
        else if (first) begin
          first = 0;
          if (sh[7:1] == SLV) begin s_drv = 1; rpend = sh[0]; end
          else begin act = 0; s_drv = 0; end
        end else begin
          if (wcnt < 4) wlog[wcnt] = sh;
          wcnt++;
          s_drv = 1;
        end
      end else if (bitc == 0) begin
        if (rpend) begin rpend = 0; sending = 1; tx = rbyte(rcnt); rcnt++; s_drv = !tx[7]; end
        else if (sending && mlast) begin tx = rbyte(rcnt); rcnt++; s_drv = !tx[7]; end
        else s_drv = 0;
      end else begin
        s_drv = sending ? !tx[7 - bitc] : 1'b0;
      end
    end
  end

  task automatic slave_clear();
    act = 0; s_drv = 0; sending = 0; rpend = 0; just = 0;
    wcnt = 0; rcnt = 0; mcnt = 0; starts = 0; stops = 0; mlast = 0;
    mack[0] = 0; mack[1] = 0;
    for (int i = 0; i < 4; i++) wlog[i] = 8'h00;
  endtask

  task automatic check(input string req, input logic [31:0] actv, input logic [31:0] expv);
    nchk++;
    if (actv !== expv) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n;
    n = 0;
    rd(3'd0, s);
    while (s[0] && n < 3000) begin
      repeat (8) @(negedge clk);
      rd(3'd0, s);
      n++;
    end
    if (s[0]) check("R2 engine did not go idle", 1, 0);
  endtask

  typedef struct packed {
    logic [1:0] p; logic rd; logic [7:0] cmd; logic [7:0] d0; logic [7:0] d1;
    logic [2:0] nw; logic [7:0] w0; logic [7:0] w1; logic [7:0] w2;
    logic [7:0] ex0; logic [7:0] ex1; logic [1:0] nst; logic [1:0] mc; logic mk0;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{2'd0, 1'b0, 8'h00, 8'h01, 8'h02, 3'd0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 2'd1, 2'd0, 1'b0},
    '{2'd0, 1'b1, 8'h00, 8'h01, 8'h02, 3'd0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 2'd1, 2'd0, 1'b0},
    '{2'd1, 1'b0, 8'h11, 8'h01, 8'h02, 3'd1, 8'h11, 8'h00, 8'h00, 8'h01, 8'h02, 2'd1, 2'd0, 1'b0},
    '{2'd1, 1'b1, 8'h00, 8'h01, 8'h02, 3'd0, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h02, 2'd1, 2'd1, 1'b0},
    '{2'd2, 1'b0, 8'h22, 8'h33, 8'h02, 3'd2, 8'h22, 8'h33, 8'h00, 8'h33, 8'h02, 2'd1, 2'd0, 1'b0},
    '{2'd2, 1'b1, 8'h44, 8'h01, 8'h02, 3'd1, 8'h44, 8'h00, 8'h00, 8'hA5, 8'h02, 2'd2, 2'd1, 1'b0},
    '{2'd3, 1'b0, 8'h55, 8'h66, 8'h77, 3'd3, 8'h55, 8'h66, 8'h77, 8'h66, 8'h77, 2'd1, 2'd0, 1'b0},
    '{2'd3, 1'b1, 8'h88, 8'h01, 8'h02, 3'd1, 8'h88, 8'h00, 8'h00, 8'hA5, 8'h3C, 2'd2, 2'd2, 1'b1}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int drive_seen;
    slave_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3'd0, v); check("R1 status after reset", v, 8'h00);
    rd(3'd2, v); check("R1 control after reset", v, 8'h00);
    check("R9 irq after reset", irq, 0);
    check("R12 lines released after reset", {scl_pull, sda_pull}, 2'b00);

    // register readback
    wr(3'd3, 8'h5A); rd(3'd3, v); check("R1 command readback", v, 8'h5A);
    wr(3'd4, 8'hC3); rd(3'd4, v); check("R1 address readback", v, 8'hC3);
    wr(3'd2, 8'h0D); rd(3'd2, v); check("R1 control readback", v, 8'h0D);
    wr(3'd2, 8'h00);
    rd(3'd7, v); check("R1 unused offset", v, 8'h00);

    // protocol table: R2 R3 R4
    foreach (VT[i]) begin
      slave_clear();
      wr(3'd4, {SLV, VT[i].rd});
      wr(3'd3, VT[i].cmd);
      wr(3'd5, VT[i].d0);
      wr(3'd6, VT[i].d1);
      wr(3'd0, 8'h1E);
      wr(3'd2, {3'b010, 1'b0, VT[i].p, 2'b00});
      wait_idle();
      rd(3'd0, v); check("R2 status completed", v, 8'h02);
      check("R2 written byte count", wcnt, VT[i].nw);
      if (VT[i].nw > 0) check("R2 first written byte", wlog[0], VT[i].w0);
      if (VT[i].nw > 1) check("R2 second written byte", wlog[1], VT[i].w1);
      if (VT[i].nw > 2) check("R2 third written byte", wlog[2], VT[i].w2);
      check("R3 START count", starts, VT[i].nst);
      check("R4 STOP count", stops, 1);
      rd(3'd5, v); check("R3 data byte 0", v, VT[i].ex0);
      rd(3'd6, v); check("R3 data byte 1", v, VT[i].ex1);
      check("R4 master acknowledge count", mcnt, VT[i].mc);
      if (VT[i].mc > 0) check("R4 first master acknowledge", mack[0], VT[i].mk0);
      if (VT[i].mc > 1) check("R4 last byte NACKed", mack[1], 0);
      check("R12 lines released after transfer", {scl_pull, sda_pull}, 2'b00);
    end

    // R9 interrupt and R8 write-one-to-clear
    slave_clear();
    wr(3'd4, {SLV, 1'b0});
    wr(3'd0, 8'h1E);
    wr(3'd2, 8'h41);
    wait_idle();
    check("R9 irq with enable and completed", irq, 1);
    wr(3'd0, 8'h01);
    rd(3'd0, v); check("R8 busy not writable, done kept", v, 8'h02);
    wr(3'd0, 8'h02);
    rd(3'd0, v); check("R8 completed cleared by one", v, 8'h00);
    check("R9 irq drops after clear", irq, 0);
    slave_clear();
    wr(3'd2, 8'h40);
    wait_idle();
    rd(3'd0, v); check("R9 completed set with enable off", v, 8'h02);
    check("R9 irq stays low with enable off", irq, 0);
    wr(3'd0, 8'h1E);

    // R5 target does not acknowledge
    slave_clear();
    wr(3'd4, {7'h22, 1'b0});
    wr(3'd2, 8'h44);
    wait_idle();
    rd(3'd0, v); check("R5 device error without completion", v, 8'h04);
    check("R5 STOP after NACK", stops, 1);
    check("R5 lines released", {scl_pull, sda_pull}, 2'b00);
    wr(3'd0, 8'h1E);

    // R6 collision
    slave_clear();
    wr(3'd4, {SLV, 1'b0});
    jam = 1'b1;
    wr(3'd2, 8'h44);
    wait_idle();
    rd(3'd0, v); check("R6 collision status", v, 8'h08);
    @(negedge clk);
    check("R6 lines released after collision", {scl_pull, sda_pull}, 2'b00);
    jam = 1'b0;
    repeat (4) @(negedge clk);
    slave_clear();
    wr(3'd0, 8'h1E);

    // R7 kill
    wr(3'd4, {SLV, 1'b1});
    wr(3'd2, 8'h4C);
    repeat (400) @(negedge clk);
    rd(3'd0, v); check("R7 busy before kill", v[0], 1);
    wr(3'd2, 8'h0E);
    rd(3'd0, v); check("R7 killed status", v, 8'h10);
    slave_clear();
    repeat (4) @(negedge clk);
    check("R7 lines released after kill", {scl_pull, sda_pull}, 2'b00);
    wr(3'd0, 8'h1E);
    repeat (20) @(negedge clk);

    // R10 start while busy
    slave_clear();
    wr(3'd4, {SLV, 1'b0});
    wr(3'd3, 8'h9A); wr(3'd5, 8'hBC); wr(3'd6, 8'hDE);
    wr(3'd2, 8'h4C);
    repeat (100) @(negedge clk);
    wr(3'd2, 8'h40);
    rd(3'd2, v); check("R10 protocol field kept while busy", v, 8'h0C);
    wait_idle();
    rd(3'd0, v); check("R10 original transfer completed", v, 8'h02);
    check("R10 all word bytes written", wcnt, 3);
    check("R10 last byte is data byte 1", wlog[2], 8'hDE);
    wr(3'd0, 8'h1E);

    // R11 reserved protocol
    slave_clear();
    wr(3'd2, 8'h54);
    rd(3'd0, v); check("R11 reserved code gives device error", v, 8'h04);
    drive_seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (scl_pull || sda_pull) drive_seen++;
    end
    check("R11 no bus activity", drive_seen, 0);
    check("R11 no START seen", starts, 0);

    finish_run();
  end
endmodule